// File: doc/BRIEF.md
# Phase Interpolator Switch Sequencer

This block is the digital controller for a 5-bit charge/discharge phase interpolator. The analog side is a capacitor node, a set of switched current cells and a threshold detector. This block never sees any of them directly. It receives four timing events:

- a precharge request;
- the rising edge of the first delayed clock edge;
- the rising edge of the second delayed clock edge, which arrives one oscillator period later;
- the detector output.

From these events it drives eleven current-cell switch enables and a precharge enable.

During the first slope, a code-dependent number of unit currents discharges the node. During the second slope, every cell is on, giving the full 32 units. The output edge therefore trails the end of the first slope by (31 − code)/32 oscillator periods plus a fixed offset.

The code has two fields:

- the low 2-bit field drives three cells of one unit each;
- the high 3-bit field drives seven cells of four units each;
- one further unit cell is on for the whole first slope.

The block also reports the following, so that a bench or a system model can follow the interpolation:

- the current weight switched on;
- the predicted edge delay in 1/32-period steps;
- its state.

Top module: `pi_switch_seq`

## Requirements
- R1: While rst_ni is low and after it is released, state_o is 0 (idle), sw_en_o is all zero, and pchg_o and out_o are low.
- R2: In the cycle after refresh_i is sampled high, from any state, state_o is 1 (precharge), pchg_o is high and sw_en_o is all zero. The block stays there while refresh_i is high.
- R3: The code is captured at the clock edge where refresh_i is first sampled low in precharge. Later changes of code_i do not alter the switch pattern or delay_o until the next precharge.
- R4: After precharge the block waits in state 2 with pchg_o low and all switches off, until a rising edge of edg1_i.
- R5: In the first slope (state 3), sw_en_o[0] is always on. Bit k (k = 1..3) is on when code[1:0] is at least k. Bit 3+j (j = 1..7) is on when code[4:2] is at least j. Code 0 gives 11'h001, code 5 gives 11'h013 and code 31 gives 11'h7FF.
- R6: units_o is the weight of the enabled cells, counting one unit for bits 0..3 and four units for bits 4..10. In the first slope it equals code+1.
- R7: A rising edge of edg2_i in the first slope moves the block to state 4 (second slope). There all eleven enables are on and units_o is 32.
- R8: When cmp_i is high in the second slope, the block moves to state 5 (hold). In hold all enables are off and out_o is high. It stays in hold until refresh_i.
- R9: delay_o equals 31 minus the captured code.
- R10: cmp_i is ignored outside the second slope, an edg1_i rise is ignored outside state 2, and an edg2_i rise is ignored outside the first slope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 5 | Interpolation code |
| refresh_i | input | 1 | Precharge request (level) |
| edg1_i | input | 1 | First delayed edge; its rise starts slope 1 |
| edg2_i | input | 1 | Second delayed edge; its rise ends slope 1 |
| cmp_i | input | 1 | Threshold detector output |
| sw_en_o | output | 11 | Current-cell switch enables |
| pchg_o | output | 1 | Precharge enable |
| out_o | output | 1 | Interpolated output edge (high in hold) |
| state_o | output | 3 | Sequencer state code |
| units_o | output | 6 | Enabled discharge weight in unit currents |
| delay_o | output | 5 | Predicted edge delay in 1/32-period steps |

## Verification
The hardest situation to reach is an event that arrives in the wrong phase, because a normal run never produces one. Examples are a detector pulse during the first slope, a second-edge rise while still waiting, or a precharge request in the middle of a slope. The bench walks the sequencer into each phase with the regular event order, then injects the out-of-phase event and reads state, enables and out_o in the next cycle. Code changes between captures are applied while the block waits, to show that only the value present at the end of precharge counts.

// File: rtl/pi_seq_pkg.sv
package pi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PCHG   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SLOPE1 = 3'd3,
    ST_SLOPE2 = 3'd4,
    ST_HOLD   = 3'd5
  } pi_state_e;
endpackage

// File: rtl/pi_code_latch.sv
module pi_code_latch #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_o <= '0;
    else if (load_i) code_o <= code_i;
  end
endmodule

// File: rtl/pi_cell_decode.sv
module pi_cell_decode #(
  parameter int LO_W = 2,
  parameter int HI_W = 3,
  localparam int CODE_W   = LO_W + HI_W,
  localparam int LO_CELLS = (1 << LO_W) - 1,
  localparam int HI_CELLS = (1 << HI_W) - 1,
  localparam int N_SW     = 1 + LO_CELLS + HI_CELLS,
  localparam int UW       = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              slope1_i,
  input  logic              slope2_i,
  output logic [N_SW-1:0]   sw_en_o,
  output logic [UW-1:0]     units_o
);
  localparam int HI_UNIT = 1 << LO_W;

  logic [LO_W-1:0]     lo;
  logic [HI_W-1:0]     hi;
  logic [LO_CELLS-1:0] lo_on;
  logic [HI_CELLS-1:0] hi_on;

  assign lo = code_i[LO_W-1:0];
  assign hi = code_i[CODE_W-1:LO_W];

  // thermometer per field
  for (genvar k = 1; k <= LO_CELLS; k++) begin : g_lo
    assign lo_on[k-1] = (lo >= LO_W'(k));
  end
  for (genvar j = 1; j <= HI_CELLS; j++) begin : g_hi
    assign hi_on[j-1] = (hi >= HI_W'(j));
  end

  always_comb begin
    if (slope2_i)      sw_en_o = '1;
    else if (slope1_i) sw_en_o = {hi_on, lo_on, 1'b1};
    else               sw_en_o = '0;
  end

  always_comb begin
    units_o = '0;
    for (int i = 0; i < N_SW; i++) begin
      if (sw_en_o[i]) units_o = units_o + ((i <= LO_CELLS) ? UW'(1) : UW'(HI_UNIT));
    end
  end
endmodule

// File: rtl/pi_seq_fsm.sv
module pi_seq_fsm
  import pi_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      refresh_i,
  input  logic      edg1_i,
  input  logic      edg2_i,
  input  logic      cmp_i,
  output pi_state_e state_o,
  output logic      load_o
);
  pi_state_e state_q, state_d;
  logic edg1_q, edg2_q;
  logic edg1_rise, edg2_rise;

  assign edg1_rise = edg1_i & ~edg1_q;
  assign edg2_rise = edg2_i & ~edg2_q;
  // capture point: precharge ends
  assign load_o    = (state_q == ST_PCHG) & ~refresh_i;

  always_comb begin
    state_d = state_q;
    if (refresh_i) state_d = ST_PCHG;
    else begin
      unique case (state_q)
        ST_PCHG:   state_d = ST_WAIT;
        ST_WAIT:   if (edg1_rise) state_d = ST_SLOPE1;
        ST_SLOPE1: if (edg2_rise) state_d = ST_SLOPE2;
        ST_SLOPE2: if (cmp_i)     state_d = ST_HOLD;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edg1_q  <= 1'b0;
      edg2_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      edg1_q  <= edg1_i;
      edg2_q  <= edg2_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pi_switch_seq.sv
module pi_switch_seq
  import pi_seq_pkg::*;
#(
  parameter int LO_W = 2,
  parameter int HI_W = 3,
  localparam int CODE_W = LO_W + HI_W,
  localparam int N_SW   = (1 << LO_W) + (1 << HI_W) - 1,
  localparam int UW     = CODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              refresh_i,
  input  logic              edg1_i,
  input  logic              edg2_i,
  input  logic              cmp_i,
  output logic [N_SW-1:0]   sw_en_o,
  output logic              pchg_o,
  output logic              out_o,
  output logic [2:0]        state_o,
  output logic [UW-1:0]     units_o,
  output logic [CODE_W-1:0] delay_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  pi_state_e         state;
  logic              load;
  logic [CODE_W-1:0] code_q;

  pi_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .refresh_i(refresh_i),
    .edg1_i   (edg1_i),
    .edg2_i   (edg2_i),
    .cmp_i    (cmp_i),
    .state_o  (state),
    .load_o   (load)
  );

  pi_code_latch #(.CODE_W(CODE_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .code_i(code_i),
    .code_o(code_q)
  );

  pi_cell_decode #(.LO_W(LO_W), .HI_W(HI_W)) u_dec (
    .code_i  (code_q),
    .slope1_i(state == ST_SLOPE1),
    .slope2_i(state == ST_SLOPE2),
    .sw_en_o (sw_en_o),
    .units_o (units_o)
  );

  assign pchg_o  = (state == ST_PCHG);
  assign out_o   = (state == ST_HOLD);
  assign state_o = state;
  assign delay_o = MAX_CODE - code_q;
endmodule

// File: rtl/pi_switch_seq_chk.sv
module pi_switch_seq_chk #(
  parameter int LO_W = 2,
  parameter int HI_W = 3,
  localparam int CODE_W = LO_W + HI_W,
  localparam int N_SW   = (1 << LO_W) + (1 << HI_W) - 1,
  localparam int UW     = CODE_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              refresh_i,
  input logic              cmp_i,
  input logic [N_SW-1:0]   sw_en_o,
  input logic              pchg_o,
  input logic              out_o,
  input logic [2:0]        state_o,
  input logic [UW-1:0]     units_o,
  input logic [CODE_W-1:0] delay_o
);
  localparam int FULL = 1 << CODE_W;

  AST_REFRESH_PCHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (pchg_o && sw_en_o == '0 && state_o == 3'd1)); // R2

  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) != 3'd1) |-> $stable(delay_o)); // R3

  AST_WAIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2) |-> (sw_en_o == '0 && !pchg_o)); // R4

  AST_SW0_SLOPE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> sw_en_o[0]); // R5

  AST_SLOPE1_UNITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> (units_o == UW'(FULL) - UW'(delay_o))); // R6

  AST_SLOPE2_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |-> (&sw_en_o && units_o == UW'(FULL))); // R7

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5) |-> (sw_en_o == '0 && out_o)); // R8

  AST_CMP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && cmp_i && !refresh_i) |=> (state_o == 3'd3 || state_o == 3'd4)); // R10
endmodule

bind pi_switch_seq pi_switch_seq_chk #(.LO_W(LO_W), .HI_W(HI_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .refresh_i(refresh_i),
  .cmp_i    (cmp_i),
  .sw_en_o  (sw_en_o),
  .pchg_o   (pchg_o),
  .out_o    (out_o),
  .state_o  (state_o),
  .units_o  (units_o),
  .delay_o  (delay_o)
);

// File: tb/pi_switch_seq_tb.sv
module pi_switch_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] code_i = '0;
  logic refresh_i = 1'b0, edg1_i = 1'b0, edg2_i = 1'b0, cmp_i = 1'b0;
  logic [10:0] sw_en_o;
  logic pchg_o, out_o;
  logic [2:0] state_o;
  logic [5:0] units_o;
  logic [4:0] delay_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  pi_switch_seq dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive after negedge, observe after next posedge
  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [10:0] exp_sw(input logic [4:0] c);
    logic [10:0] e = 11'h001;
    for (int k = 1; k <= 3; k++) if (int'(c[1:0]) >= k) e[k] = 1'b1;
    for (int j = 1; j <= 7; j++) if (int'(c[4:2]) >= j) e[3+j] = 1'b1;
    return e;
  endfunction

  task automatic t_reset();
    chk("R1 state", state_o, 0);
    chk("R1 sw", sw_en_o, 0);
    chk("R1 pchg/out", {pchg_o, out_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    tick();
    chk("R1 idle after release", state_o, 0);
    chk("R1 sw after release", sw_en_o, 0);
  endtask

  task automatic t_run(input logic [4:0] c);
    @(negedge clk_i); refresh_i = 1'b1; code_i = c;
    tick();
    chk("R2 state", state_o, 1);
    chk("R2 pchg", pchg_o, 1);
    chk("R2 sw", sw_en_o, 0);
    @(negedge clk_i); refresh_i = 1'b0;
    tick();
    chk("R4 wait state", state_o, 2);
    chk("R4 pchg low", pchg_o, 0);
    chk("R9 delay", delay_o, 31 - int'(c));
    @(negedge clk_i); code_i = ~c;
    tick(); tick();
    chk("R4 sw off while waiting", sw_en_o, 0);
    chk("R3 delay kept", delay_o, 31 - int'(c));
    @(negedge clk_i); edg1_i = 1'b1;
    tick();
    chk("R5 slope1 state", state_o, 3);
    chk("R5 pattern", sw_en_o, exp_sw(c));
    chk("R6 units", units_o, int'(c) + 1);
    tick();
    chk("R5 held in slope1", state_o, 3);
    @(negedge clk_i); edg2_i = 1'b1;
    tick();
    chk("R7 slope2 state", state_o, 4);
    chk("R7 all on", sw_en_o, 11'h7FF);
    chk("R7 units", units_o, 32);
    tick();
    chk("R8 waits for cmp", state_o, 4);
    @(negedge clk_i); cmp_i = 1'b1;
    tick();
    chk("R8 hold state", state_o, 5);
    chk("R8 out", out_o, 1);
    chk("R8 sw off", sw_en_o, 0);
    @(negedge clk_i); cmp_i = 1'b0; edg1_i = 1'b0; edg2_i = 1'b0;
    tick(); tick();
    chk("R8 stays hold", {state_o, out_o}, {3'd5, 1'b1});
  endtask

  task automatic t_ignore();
    @(negedge clk_i); refresh_i = 1'b1; code_i = 5'd9;
    tick();
    @(negedge clk_i); refresh_i = 1'b0;
    tick();
    @(negedge clk_i); cmp_i = 1'b1; edg2_i = 1'b1;
    tick();
    chk("R10 cmp/edg2 ignored in wait", state_o, 2);
    @(negedge clk_i); cmp_i = 1'b0; edg2_i = 1'b0; edg1_i = 1'b1;
    tick();
    chk("R10 slope1 entered", state_o, 3);
    @(negedge clk_i); cmp_i = 1'b1;
    tick();
    chk("R10 cmp ignored in slope1", state_o, 3);
    chk("R10 pattern unchanged", sw_en_o, exp_sw(5'd9));
    @(negedge clk_i); cmp_i = 1'b0; edg2_i = 1'b1;
    tick();
    @(negedge clk_i); cmp_i = 1'b1;
    tick();
    chk("R10 hold reached", state_o, 5);
    @(negedge clk_i); cmp_i = 1'b0; edg1_i = 1'b0; edg2_i = 1'b0;
    tick();
    @(negedge clk_i); edg1_i = 1'b1; edg2_i = 1'b1;
    tick();
    chk("R10 edges ignored in hold", state_o, 5);
    @(negedge clk_i); edg1_i = 1'b0; edg2_i = 1'b0;
    tick();
  endtask

  task automatic t_abort();
    @(negedge clk_i); refresh_i = 1'b1; code_i = 5'd22;
    tick();
    @(negedge clk_i); refresh_i = 1'b0;
    tick();
    @(negedge clk_i); edg1_i = 1'b1;
    tick();
    chk("R5 abort run slope1", sw_en_o, exp_sw(5'd22));
    @(negedge clk_i); refresh_i = 1'b1; code_i = 5'd3;
    tick();
    chk("R2 abort to precharge", state_o, 1);
    chk("R2 abort sw off", sw_en_o, 0);
    tick();
    chk("R2 stays precharge", {state_o, pchg_o}, {3'd1, 1'b1});
    @(negedge clk_i); refresh_i = 1'b0; edg1_i = 1'b0;
    tick();
    chk("R3 new code captured", delay_o, 28);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    t_run(5'd0);
    t_run(5'd5);
    t_run(5'd31);
    t_run(5'd10);
    t_run(5'd19);
    t_ignore();
    t_abort();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule